// File: doc/BRIEF.md
# Dual-Mode Packet Buffer

This block sits between a streaming network pipeline and a packet-processing CPU. It holds a single circular memory of 64-bit words and alternates between two roles. In stream mode it takes in the next packet from the input stream. At the same time it plays out, on the output stream, the packet that the CPU has just finished with. Once both of these are complete it changes to CPU mode and raises `pkt_ready`. In CPU mode the memory acts as plain random-access data memory, and the stored packet's first and last word addresses are visible on `pkt_head` and `pkt_tail`. A pulse on `cpu_done` returns the block to stream mode and starts playout of the packet as the CPU left it.

Random access in CPU mode comes through one of two ports: the CPU's memory-stage port or the host register port. `user_mode` selects which one, and the read data of the chosen port is returned one cycle later. The output stream has no back-pressure and presents one beat per cycle once playout has begun. The input stream is held off with `in_ready` low in CPU mode, and also in stream mode once a whole packet has arrived.

Top module: `pktbuf_dualmode`

## Requirements
- R1: After reset the block is in stream mode with `in_ready` = 1, `pkt_ready` = 0 and `out_valid` = 0. Nothing is played out until the CPU has released a packet.
- R2: Each accepted input beat is stored at the address after the previous accepted beat, and the address wraps from 255 to 0. `pkt_head` shows the address of the beat that carried `in_sop`, and `pkt_tail` shows the address of the beat that carried `in_eop`. After a wrap, `pkt_tail` can be numerically below `pkt_head`. A packet of one beat has equal head and tail.
- R3: Once a beat with `in_eop` = 1 is accepted, `in_ready` stays 0 until the block returns to stream mode. `in_ready` is 0 throughout CPU mode, so beats offered at those times are not stored.
- R4: `pkt_ready` rises on the first cycle after a cycle in which the whole input packet has been received and no playout is still being issued. This is two cycles after the eop beat when no playout is in progress.
- R5: A cycle with `pkt_ready` = 1 and `cpu_done` = 1 drops `pkt_ready` and raises `in_ready` on the next cycle. Two cycles after the `cpu_done` cycle, playout begins: one beat per cycle, from the head address through to the tail address, with `out_sop` on the first beat and `out_eop` on the last.
- R6: Playout returns the memory contents as they stand after the CPU's changes, not as they were received.
- R7: In CPU mode, `user_mode` = 1 selects the CPU port (`cpu_addr`, `cpu_wdata`, `cpu_we`) and `user_mode` = 0 selects the host port. `acc_rdata` returns the word at the selected address one cycle later. A write and a read of the same address in the same cycle return the old word.
- R8: Writes on the port that `user_mode` does not select have no effect. Writes on either access port have no effect in stream mode.
- R9: `cpu_done` has no effect while `pkt_ready` is 0.
- R10: In stream mode, receiving the next packet and playing out the previous one go on in the same cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; both memory ports use its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 64 | Input stream word |
| in_sop | input | 1 | Input beat is the first of a packet |
| in_eop | input | 1 | Input beat is the last of a packet |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block accepts an input beat this cycle |
| out_data | output | 64 | Output stream word |
| out_sop | output | 1 | Output beat is the first of a packet |
| out_eop | output | 1 | Output beat is the last of a packet |
| out_valid | output | 1 | Output beat present |
| user_mode | input | 1 | 1: CPU port owns random access, 0: host port does |
| cpu_addr | input | 8 | CPU port word address |
| cpu_wdata | input | 64 | CPU port write data |
| cpu_we | input | 1 | CPU port write enable |
| host_addr | input | 8 | Host port word address |
| host_wdata | input | 64 | Host port write data |
| host_we | input | 1 | Host port write enable |
| acc_rdata | output | 64 | Read data of the selected access port, one cycle after the address |
| pkt_ready | output | 1 | A packet is held for the CPU (CPU mode) |
| cpu_done | input | 1 | CPU has finished with the held packet |
| pkt_head | output | 8 | Address of the held packet's first word |
| pkt_tail | output | 8 | Address of the held packet's last word |

## Verification
The assertions take several things as given about the block's inputs. Every input packet opens with an sop beat and closes with an eop beat. No packet is longer than the memory. The words of the packet being received never reach the words of the packet being played out. The stimulus meets these conditions by building every packet in one task that flags its first and last beats. Packet lengths stay between 1 and 60 beats, so a new packet always begins directly after the previous tail and cannot run over the packet still being drained. Stray beats, `cpu_done` pulses and access-port writes are deliberately offered at the moments when the requirements say they must be ignored.

// File: rtl/pktbuf_pkg.sv
package pktbuf_pkg;

  typedef enum logic {
    MODE_STREAM = 1'b0,
    MODE_CPU    = 1'b1
  } buf_mode_e;

endpackage

// File: rtl/pktbuf_ram.sv
// Simple dual-port memory, one write port and one read-first read port.
module pktbuf_ram #(
  parameter int DW = 64,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/pktbuf_rx.sv
// Receive side: write pointer, boundaries of the latest packet, completion flag.
module pktbuf_rx #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic          sop,
  input  logic          eop,
  input  logic          clear,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] head,
  output logic [AW-1:0] tail,
  output logic          done
);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      head   <= '0;
      tail   <= '0;
      done   <= 1'b0;
    end else begin
      if (clear) done <= 1'b0;
      if (accept) begin
        if (sop) head <= wr_ptr;
        if (eop) begin
          tail <= wr_ptr;
          done <= 1'b1;
        end
        wr_ptr <= wr_ptr + 1'b1;
      end
    end
  end

  // R3: once the packet is complete the top must not hand in further beats
  assert_no_accept_after_eop_R3: assert property (@(posedge clk) disable iff (rst)
    accept |-> !done);

  // R2: clear (mode change) and beat acceptance never coincide
  assert_clear_not_accept_R2: assert property (@(posedge clk) disable iff (rst)
    clear |-> !accept);

endmodule

// File: rtl/pktbuf_tx.sv
// Playout side: walks from first to last address, flags aligned with RAM output.
module pktbuf_tx #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] first_addr,
  input  logic [AW-1:0] last_addr,
  output logic [AW-1:0] rd_ptr,
  output logic          busy,
  output logic          beat_valid,
  output logic          beat_sop,
  output logic          beat_eop
);
  logic [AW-1:0] end_addr;
  logic          first;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr     <= '0;
      end_addr   <= '0;
      busy       <= 1'b0;
      first      <= 1'b0;
      beat_valid <= 1'b0;
      beat_sop   <= 1'b0;
      beat_eop   <= 1'b0;
    end else begin
      beat_valid <= 1'b0;
      beat_sop   <= 1'b0;
      beat_eop   <= 1'b0;
      if (start) begin
        busy     <= 1'b1;
        rd_ptr   <= first_addr;
        end_addr <= last_addr;
        first    <= 1'b1;
      end else if (busy) begin
        beat_valid <= 1'b1;
        beat_sop   <= first;
        beat_eop   <= (rd_ptr == end_addr);
        first      <= 1'b0;
        rd_ptr     <= rd_ptr + 1'b1;
        if (rd_ptr == end_addr) busy <= 1'b0;
      end
    end
  end

  // R5: each playout burst opens with the sop beat
  assert_sop_opens_burst_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(beat_valid) |-> beat_sop);

  // R5: the eop beat closes the burst
  assert_eop_closes_burst_R5: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && beat_eop) |=> !beat_valid);

endmodule

// File: rtl/pktbuf_dualmode.sv
module pktbuf_dualmode #(
  parameter int DW = 64,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] in_data,
  input  logic          in_sop,
  input  logic          in_eop,
  input  logic          in_valid,
  output logic          in_ready,
  output logic [DW-1:0] out_data,
  output logic          out_sop,
  output logic          out_eop,
  output logic          out_valid,
  input  logic          user_mode,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  input  logic          cpu_we,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  input  logic          host_we,
  output logic [DW-1:0] acc_rdata,
  output logic          pkt_ready,
  input  logic          cpu_done,
  output logic [AW-1:0] pkt_head,
  output logic [AW-1:0] pkt_tail
);
  import pktbuf_pkg::*;

  buf_mode_e     mode;
  logic          stream;
  logic          accept;
  logic          release_pkt;
  logic          rx_done;
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;
  logic          tx_busy;
  logic [AW-1:0] sel_addr;
  logic [DW-1:0] sel_wdata;
  logic          sel_we;
  logic          ram_we;
  logic [AW-1:0] ram_waddr;
  logic [DW-1:0] ram_wdata;
  logic [AW-1:0] ram_raddr;
  logic [DW-1:0] ram_rdata;

  assign stream      = (mode == MODE_STREAM);
  assign in_ready    = stream && !rx_done;
  assign accept      = in_valid && in_ready;
  assign release_pkt = !stream && cpu_done;

  // access-port select for random access
  assign sel_addr  = user_mode ? cpu_addr  : host_addr;
  assign sel_wdata = user_mode ? cpu_wdata : host_wdata;
  assign sel_we    = user_mode ? cpu_we    : host_we;

  // memory ports follow the mode
  assign ram_we    = stream ? accept  : sel_we;
  assign ram_waddr = stream ? wr_ptr  : sel_addr;
  assign ram_wdata = stream ? in_data : sel_wdata;
  assign ram_raddr = stream ? rd_ptr  : sel_addr;

  pktbuf_ram #(.DW(DW), .AW(AW)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .raddr (ram_raddr),
    .rdata (ram_rdata)
  );

  pktbuf_rx #(.AW(AW)) u_rx (
    .clk    (clk),
    .rst    (rst),
    .accept (accept),
    .sop    (in_sop),
    .eop    (in_eop),
    .clear  (release_pkt),
    .wr_ptr (wr_ptr),
    .head   (pkt_head),
    .tail   (pkt_tail),
    .done   (rx_done)
  );

  pktbuf_tx #(.AW(AW)) u_tx (
    .clk        (clk),
    .rst        (rst),
    .start      (release_pkt),
    .first_addr (pkt_head),
    .last_addr  (pkt_tail),
    .rd_ptr     (rd_ptr),
    .busy       (tx_busy),
    .beat_valid (out_valid),
    .beat_sop   (out_sop),
    .beat_eop   (out_eop)
  );

  assign out_data  = ram_rdata;
  assign acc_rdata = ram_rdata;

  // two-state controller
  always_ff @(posedge clk) begin
    if (rst) begin
      mode      <= MODE_STREAM;
      pkt_ready <= 1'b0;
    end else begin
      case (mode)
        MODE_STREAM: if (rx_done && !tx_busy) begin
          mode      <= MODE_CPU;
          pkt_ready <= 1'b1;
        end
        MODE_CPU: if (cpu_done) begin
          mode      <= MODE_STREAM;
          pkt_ready <= 1'b0;
        end
        default: mode <= MODE_STREAM;
      endcase
    end
  end

  // R4: pkt_ready only after receive complete and playout finished
  assert_ready_entry_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(pkt_ready) |-> ($past(rx_done) && !$past(tx_busy)));

  // R4: no playout is in flight while the CPU owns the memory
  assert_no_drain_in_cpu_R4: assert property (@(posedge clk) disable iff (rst)
    pkt_ready |-> !tx_busy);

  // R5: cpu_done hands the memory back to the stream side
  assert_done_returns_R5: assert property (@(posedge clk) disable iff (rst)
    (pkt_ready && cpu_done) |=> (!pkt_ready && in_ready));

  // R3: eop beat closes the input
  assert_eop_closes_input_R3: assert property (@(posedge clk) disable iff (rst)
    (accept && in_eop) |=> !in_ready);

  // R9: cpu_done outside CPU mode changes nothing
  assert_done_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (!pkt_ready && cpu_done && !(rx_done && !tx_busy)) |=> !pkt_ready);

  // R2: packet boundaries hold while the CPU works
  assert_bounds_stable_R2: assert property (@(posedge clk) disable iff (rst)
    pkt_ready |=> ($stable(pkt_head) && $stable(pkt_tail)));

endmodule

// File: tb/pktbuf_dualmode_test.sv
module pktbuf_dualmode_test;
  localparam int DW = 64;
  localparam int AW = 8;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [DW-1:0] in_data = '0;
  logic          in_sop = 1'b0, in_eop = 1'b0, in_valid = 1'b0;
  logic          in_ready;
  logic [DW-1:0] out_data;
  logic          out_sop, out_eop, out_valid;
  logic          user_mode = 1'b1;
  logic [AW-1:0] cpu_addr = '0, host_addr = '0;
  logic [DW-1:0] cpu_wdata = '0, host_wdata = '0;
  logic          cpu_we = 1'b0, host_we = 1'b0;
  logic [DW-1:0] acc_rdata;
  logic          pkt_ready;
  logic          cpu_done = 1'b0;
  logic [AW-1:0] pkt_head, pkt_tail;

  pktbuf_dualmode #(.DW(DW), .AW(AW)) uut (
    .clk(clk), .rst(rst),
    .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop), .in_valid(in_valid),
    .in_ready(in_ready),
    .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop), .out_valid(out_valid),
    .user_mode(user_mode),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_we(cpu_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_we(host_we),
    .acc_rdata(acc_rdata), .pkt_ready(pkt_ready), .cpu_done(cpu_done),
    .pkt_head(pkt_head), .pkt_tail(pkt_tail)
  );

  always #4 clk = ~clk;  // 125 MHz

  int    n_chk = 0;
  int    n_bad = 0;
  int    cyc = 0;
  int    overlap = 0;
  string cur_tag = "";

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, cur_tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [DW-1:0] m_mem [DEPTH];
  bit            m_stream, m_rxd, m_pr, m_first;
  int            m_wptr, m_head, m_tail;
  int            txq[$];
  bit            e_ov, e_sop, e_eop, e_rdv;
  logic [DW-1:0] e_od, e_rd;
  bit            was_active, old_rxd;
  int            a, sa;
  bit            swe;
  logic [DW-1:0] swd;

  always @(posedge clk) begin
    if (rst) begin
      m_stream = 1; m_rxd = 0; m_pr = 0; m_first = 0;
      m_wptr = 0; m_head = 0; m_tail = 0;
      txq.delete();
      e_ov = 0; e_sop = 0; e_eop = 0; e_rdv = 0;
    end else begin
      was_active = (txq.size() != 0);
      old_rxd    = m_rxd;
      sa  = user_mode ? int'(cpu_addr) : int'(host_addr);
      swe = user_mode ? cpu_we : host_we;
      swd = user_mode ? cpu_wdata : host_wdata;
      e_ov = 0; e_sop = 0; e_eop = 0; e_rdv = 0;
      if (m_stream) begin
        if (was_active) begin
          a = txq.pop_front();
          e_ov = 1; e_od = m_mem[a]; e_sop = m_first; e_eop = (txq.size() == 0);
          m_first = 0;
        end
        if (in_valid && !m_rxd) begin
          m_mem[m_wptr] = in_data;
          if (in_sop) m_head = m_wptr;
          if (in_eop) begin m_tail = m_wptr; m_rxd = 1; end
          m_wptr = (m_wptr + 1) % DEPTH;
        end
        if (old_rxd && !was_active) begin m_stream = 0; m_pr = 1; end
      end else begin
        e_rd = m_mem[sa]; e_rdv = 1;
        if (swe) m_mem[sa] = swd;
        if (cpu_done) begin
          m_stream = 1; m_pr = 0; m_rxd = 0; m_first = 1;
          a = m_head;
          forever begin
            txq.push_back(a);
            if (a == m_tail) break;
            a = (a + 1) % DEPTH;
          end
        end
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk("R3 in_ready", {63'd0, in_ready}, {63'd0, (m_stream && !m_rxd)});
      chk("R4 pkt_ready", {63'd0, pkt_ready}, {63'd0, m_pr});
      chk("R5 out_valid", {63'd0, out_valid}, {63'd0, e_ov});
      if (e_ov) begin
        chk("R5 out_data", out_data, e_od);
        chk("R5 out_sop", {63'd0, out_sop}, {63'd0, e_sop});
        chk("R5 out_eop", {63'd0, out_eop}, {63'd0, e_eop});
      end
      if (m_pr) begin
        chk("R2 pkt_head", {56'd0, pkt_head}, 64'(m_head));
        chk("R2 pkt_tail", {56'd0, pkt_tail}, 64'(m_tail));
      end
      if (e_rdv) chk("R7 acc_rdata", acc_rdata, e_rd);
      if (in_valid && in_ready && out_valid) overlap++;
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_bad++;
      $display("FAIL R4 watchdog actual=%0d cycles expected=below 50000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic send_pkt(input int id, input int len, input int gap);
    for (int i = 0; i < len; i++) begin
      bit acc;
      in_valid = 1; in_data = (64'(id) << 32) | 64'(i);
      in_sop = (i == 0); in_eop = (i == len - 1);
      forever begin
        acc = in_ready;
        @(negedge clk);
        if (acc) break;
      end
      in_valid = 0; in_sop = 0; in_eop = 0;
      for (int g = 0; g < gap; g++) @(negedge clk);
    end
  endtask

  task automatic wait_ready();
    while (!pkt_ready) @(negedge clk);
  endtask

  task automatic release_cpu();
    cpu_done = 1; @(negedge clk); cpu_done = 0;
  endtask

  task automatic cpu_acc(input int addr, input bit we, input logic [DW-1:0] d);
    user_mode = 1; cpu_addr = AW'(addr); cpu_we = we; cpu_wdata = d;
    @(negedge clk); cpu_we = 0;
  endtask

  task automatic host_acc(input int addr, input bit we, input logic [DW-1:0] d);
    user_mode = 0; host_addr = AW'(addr); host_we = we; host_wdata = d;
    @(negedge clk); host_we = 0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    // R1 reset state, sampled at the first negedge after release
    @(negedge clk);
    chk("R1 in_ready after reset", {63'd0, in_ready}, 64'd1);
    chk("R1 pkt_ready after reset", {63'd0, pkt_ready}, 64'd0);
    chk("R1 out_valid after reset", {63'd0, out_valid}, 64'd0);

    // R9: cpu_done while no packet is held
    cur_tag = "R9";
    release_cpu();
    chk("R9 pkt_ready after stray done", {63'd0, pkt_ready}, 64'd0);

    // packet 1, five beats
    cur_tag = "R2 R4";
    send_pkt(1, 5, 0);
    wait_ready();
    chk("R2 head of first packet", {56'd0, pkt_head}, 64'd0);
    chk("R2 tail of first packet", {56'd0, pkt_tail}, 64'd4);

    // R7 CPU port reads and read-during-write
    cur_tag = "R7";
    for (int i = 0; i < 5; i++) cpu_acc(i, 0, '0);
    cpu_acc(2, 1, 64'hDEAD_BEEF_0000_0002);
    cpu_acc(2, 0, '0);
    // R8: host write while CPU port selected
    cur_tag = "R8";
    user_mode = 1; cpu_addr = 8'd3; host_addr = 8'd3; host_we = 1; host_wdata = 64'hBAD0_BAD0_BAD0_BAD0;
    @(negedge clk); host_we = 0;
    cpu_acc(3, 0, '0);
    @(negedge clk);
    chk("R8 unselected host write ignored", acc_rdata, (64'd1 << 32) | 64'd3);

    // R5 R6 R10: release, playout overlaps next receive; CPU writes in stream mode ignored
    release_cpu();
    cur_tag = "R5 R6 R8 R10";
    user_mode = 1; cpu_addr = 8'd4; cpu_wdata = 64'hBAD1_BAD1_BAD1_BAD1; cpu_we = 1;
    send_pkt(2, 8, 0);
    cpu_we = 0;
    wait_ready();

    // R7 host port owns access, R8 CPU write ignored
    cur_tag = "R7 R8";
    host_acc(6, 0, '0);
    user_mode = 0; host_addr = 8'd7; cpu_addr = 8'd7; cpu_we = 1; cpu_wdata = 64'hBAD2_BAD2_BAD2_BAD2;
    @(negedge clk); cpu_we = 0;
    host_acc(7, 0, '0);
    host_acc(8, 1, 64'hFEED_0000_0000_0008);
    host_acc(8, 0, '0);
    release_cpu();

    // R3: stray beats after eop and during CPU mode
    cur_tag = "R3";
    send_pkt(3, 60, 1);
    in_valid = 1; in_sop = 1; in_data = 64'hBAD3_BAD3_BAD3_BAD3;
    repeat (4) @(negedge clk);
    in_valid = 0; in_sop = 0;
    wait_ready();
    in_valid = 1; repeat (2) @(negedge clk); in_valid = 0;
    chk("R3 head after stray beats", {56'd0, pkt_head}, 64'd13);
    release_cpu();

    // fill up to the wrap point
    cur_tag = "R5 R10";
    for (int p = 0; p < 3; p++) begin
      send_pkt(4 + p, 60, p % 2);
      wait_ready();
      release_cpu();
    end
    // R2: packet crossing address 255 -> 0
    cur_tag = "R2 wrap";
    send_pkt(7, 10, 0);
    wait_ready();
    chk("R2 tail below head", {63'd0, (pkt_tail < pkt_head)}, 64'd1);
    chk("R2 wrap head", {56'd0, pkt_head}, 64'd253);
    chk("R2 wrap tail", {56'd0, pkt_tail}, 64'd6);
    cpu_acc(0, 0, '0);
    cpu_acc(255, 0, '0);
    release_cpu();

    // R2 R5: single-beat packet
    cur_tag = "R2 R5 single";
    send_pkt(8, 1, 0);
    wait_ready();
    chk("R2 single head equals tail", {56'd0, pkt_head}, {56'd0, pkt_tail});
    release_cpu();
    repeat (20) @(negedge clk);

    chk("R10 receive overlapped playout", {63'd0, (overlap > 0)}, 64'd1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule